// File: doc/BRIEF.md
# Cascadable Magnitude Comparator

This block compares two unsigned binary words and reports their relation on three flags: A above B, A equal to B and A below B. It is purely combinational, with no clock and no state. Each internal stage handles a four-bit slice. A stage scans its bit pairs from the most significant downward, and the highest position where the two words differ sets the result. Lower positions do not affect that result.

Each stage also has three cascade inputs that carry the verdict of the next less significant slice. A stage uses these inputs only when all of its own bit pairs match, and in that case it copies them to its outputs unchanged. The top module chains stages from the least significant slice upward, so the verdict of the most significant stage is the verdict for the whole word. With the default parameters, two four-bit stages form an eight-bit comparator: bits 7:4 go to the upper stage and bits 3:0 to the lower one.

The cascade pins of the top module feed the least significant stage. For a standalone compare, tie cas_eq_i high and tie cas_gt_i and cas_lt_i low. Two top modules can be chained in the same way to compare wider words.

Top module: `mag_cmp_chain`

## Requirements
- R1: With the cascade inputs tied off (cas_gt_i=0, cas_eq_i=1, cas_lt_i=0), gt_o is 1 exactly when a_i is greater than b_i as unsigned numbers, for every one of the 65,536 operand pairs.
- R2: With the cascade inputs tied off, lt_o is 1 exactly when a_i is less than b_i as unsigned numbers, for every operand pair.
- R3: With the cascade inputs tied off, eq_o is 1 exactly when a_i equals b_i, for every operand pair.
- R4: The highest bit position where a_i and b_i differ decides the result. A 1 in a_i at that position gives gt_o=1, and a 1 in b_i gives lt_o=1. All lower bits are ignored.
- R5: When a_i equals b_i, the outputs copy the cascade inputs: gt_o=cas_gt_i, eq_o=cas_eq_i and lt_o=cas_lt_i.
- R6: When a_i differs from b_i, eq_o is 0 and the cascade inputs have no effect on any output, for all eight cascade values.
- R7: When a_i equals b_i and the cascade inputs are not one-hot (for example all zero or all one), the cascade values are copied to the outputs unchanged, with no correction.
- R8: Whenever exactly one cascade input is high, exactly one of gt_o, eq_o and lt_o is high.
- R9: When the upper four bits of the two words match, the lower four-bit stage decides the result through the cascade link into the upper stage. When the upper four bits differ, the upper stage decides and the lower bits are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 8 | Operand A, unsigned |
| b_i | input | 8 | Operand B, unsigned |
| cas_gt_i | input | 1 | Cascade in: a less significant slice found A greater |
| cas_eq_i | input | 1 | Cascade in: a less significant slice found A equal |
| cas_lt_i | input | 1 | Cascade in: a less significant slice found A less |
| gt_o | output | 1 | A greater than B |
| eq_o | output | 1 | A equal to B |
| lt_o | output | 1 | A less than B |

## Verification
The one-hot check on the outputs assumes that the three cascade inputs form a valid one-hot code; when they do not, that check is skipped and only the copy-through rule is checked. All checks are skipped while any input is unknown. The stimulus holds the cascade pins at the one-hot tie-off for the exhaustive sweep of all operand pairs. It sets them to non-one-hot values only in a few directed vectors, where the expected result is a plain copy when the words are equal, or is unaffected by the cascade pins when they differ.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

    // Relation verdict carried between stages and onto the outputs.
    typedef struct packed {
        logic gt;
        logic eq;
        logic lt;
    } rel_t;

    // Value to apply at the least significant cascade inputs.
    localparam rel_t REL_TIE = '{gt: 1'b0, eq: 1'b1, lt: 1'b0};

    // Verdict of a slice whose bits differ: cascade is not used.
    function automatic rel_t rel_local(input logic a_wins, input logic b_wins);
        rel_t r;
        r.gt = a_wins;
        r.eq = 1'b0;
        r.lt = b_wins;
        return r;
    endfunction

endpackage

// File: rtl/cmp_bit_cell.sv
module cmp_bit_cell (
    input  logic a_bit,
    input  logic b_bit,
    output logic same,
    output logic a_high,
    output logic b_high
);
    // Equality of the pair, and which operand holds the 1 when they differ.
    assign same   = ~(a_bit ^ b_bit);
    assign a_high = a_bit & ~b_bit;
    assign b_high = ~a_bit & b_bit;
endmodule

// File: rtl/cmp_prio_resolve.sv
module cmp_prio_resolve #(
    parameter int W = 4
) (
    input  logic [W-1:0] same,
    input  logic [W-1:0] a_high,
    input  logic [W-1:0] b_high,
    output logic         all_same,
    output logic         a_wins,
    output logic         b_wins
);
    // upper_same[i] is high when every bit position above i-1 matches.
    logic [W:0] upper_same;

    assign upper_same[W] = 1'b1;

    for (genvar i = W - 1; i >= 0; i--) begin : g_prefix
        assign upper_same[i] = upper_same[i+1] & same[i];
    end

    assign all_same = upper_same[0];
    assign a_wins   = |(upper_same[W:1] & a_high);
    assign b_wins   = |(upper_same[W:1] & b_high);
endmodule

// File: rtl/cmp_cascade_merge.sv
module cmp_cascade_merge
    import cmp_pkg::*;
(
    input  logic all_same,
    input  logic a_wins,
    input  logic b_wins,
    input  rel_t cas_in,
    output rel_t rel_out
);
    always_comb begin
        if (all_same) begin
            rel_out = cas_in;
        end else begin
            rel_out = rel_local(a_wins, b_wins);
        end
    end
endmodule

// File: rtl/cmp_stage.sv
module cmp_stage
    import cmp_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  rel_t         cas_in,
    output rel_t         rel_out
);
    logic [W-1:0] same;
    logic [W-1:0] a_high;
    logic [W-1:0] b_high;
    logic         all_same;
    logic         a_wins;
    logic         b_wins;

    for (genvar i = 0; i < W; i++) begin : g_bits
        cmp_bit_cell u_cell (
            .a_bit  (a[i]),
            .b_bit  (b[i]),
            .same   (same[i]),
            .a_high (a_high[i]),
            .b_high (b_high[i])
        );
    end

    cmp_prio_resolve #(.W(W)) u_resolve (
        .same     (same),
        .a_high   (a_high),
        .b_high   (b_high),
        .all_same (all_same),
        .a_wins   (a_wins),
        .b_wins   (b_wins)
    );

    cmp_cascade_merge u_merge (
        .all_same (all_same),
        .a_wins   (a_wins),
        .b_wins   (b_wins),
        .cas_in   (cas_in),
        .rel_out  (rel_out)
    );
endmodule

// File: rtl/mag_cmp_chain.sv
module mag_cmp_chain
    import cmp_pkg::*;
#(
    parameter int STAGE_W    = 4,
    parameter int NUM_STAGES = 2,
    localparam int WORD_W    = STAGE_W * NUM_STAGES
) (
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_i,
    input  logic              cas_gt_i,
    input  logic              cas_eq_i,
    input  logic              cas_lt_i,
    output logic              gt_o,
    output logic              eq_o,
    output logic              lt_o
);
    // link[k] feeds stage k; link[NUM_STAGES] is the whole-word verdict.
    rel_t link [NUM_STAGES+1];

    assign link[0] = '{gt: cas_gt_i, eq: cas_eq_i, lt: cas_lt_i};

    for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
        cmp_stage #(.W(STAGE_W)) u_stage (
            .a       (a_i[k*STAGE_W +: STAGE_W]),
            .b       (b_i[k*STAGE_W +: STAGE_W]),
            .cas_in  (link[k]),
            .rel_out (link[k+1])
        );
    end

    assign gt_o = link[NUM_STAGES].gt;
    assign eq_o = link[NUM_STAGES].eq;
    assign lt_o = link[NUM_STAGES].lt;
endmodule

// File: rtl/mag_cmp_chain_chk.sv
module mag_cmp_chain_chk #(
    parameter int WORD_W = 8
) (
    input logic [WORD_W-1:0] a_i,
    input logic [WORD_W-1:0] b_i,
    input logic              cas_gt_i,
    input logic              cas_eq_i,
    input logic              cas_lt_i,
    input logic              gt_o,
    input logic              eq_o,
    input logic              lt_o
);
    logic known;
    logic cas_onehot;

    assign known      = !$isunknown({a_i, b_i, cas_gt_i, cas_eq_i, cas_lt_i});
    assign cas_onehot = $onehot({cas_gt_i, cas_eq_i, cas_lt_i});

    always_comb begin
        if (known) begin
            // R8
            onehot_out_chk: assert (!cas_onehot || $onehot({gt_o, eq_o, lt_o}))
                else $error("outputs not one-hot");
            // R5
            equal_copy_chk: assert (a_i != b_i ||
                                    {gt_o, eq_o, lt_o} == {cas_gt_i, cas_eq_i, cas_lt_i})
                else $error("cascade not copied on equal words");
            // R6
            differ_noeq_chk: assert (a_i == b_i || !eq_o)
                else $error("eq_o high on differing words");
            // R1
            gt_order_chk: assert (a_i == b_i || gt_o == (a_i > b_i))
                else $error("gt_o disagrees with order");
            // R2
            lt_order_chk: assert (a_i == b_i || lt_o == (a_i < b_i))
                else $error("lt_o disagrees with order");
        end
    end
endmodule

bind mag_cmp_chain mag_cmp_chain_chk #(.WORD_W(WORD_W)) u_chk (
    .a_i      (a_i),
    .b_i      (b_i),
    .cas_gt_i (cas_gt_i),
    .cas_eq_i (cas_eq_i),
    .cas_lt_i (cas_lt_i),
    .gt_o     (gt_o),
    .eq_o     (eq_o),
    .lt_o     (lt_o)
);

// File: tb/test_mag_cmp_chain.sv
module test_mag_cmp_chain;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] a_i = '0;
    logic [7:0] b_i = '0;
    logic       cas_gt_i = 1'b0;
    logic       cas_eq_i = 1'b1;
    logic       cas_lt_i = 1'b0;
    logic       gt_o, eq_o, lt_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    typedef struct {
        logic [2:0] expv;
        string      req;
        logic [7:0] a;
        logic [7:0] b;
    } item_t;

    item_t sb_q[$];

    always #5 clk = ~clk;

    mag_cmp_chain i_mag_cmp_chain (
        .a_i(a_i), .b_i(b_i),
        .cas_gt_i(cas_gt_i), .cas_eq_i(cas_eq_i), .cas_lt_i(cas_lt_i),
        .gt_o(gt_o), .eq_o(eq_o), .lt_o(lt_o)
    );

    // Reference: unsigned relational operators; equal words copy the cascade.
    function automatic logic [2:0] ref_rel(logic [7:0] a, logic [7:0] b, logic [2:0] cas);
        if (a > b)      return 3'b100;
        else if (a < b) return 3'b001;
        else            return cas;
    endfunction

    task automatic drive(input logic [7:0] a, input logic [7:0] b,
                         input logic [2:0] cas, input string req);
        item_t it;
        @(posedge clk);
        a_i = a;
        b_i = b;
        {cas_gt_i, cas_eq_i, cas_lt_i} = cas;
        it.expv = ref_rel(a, b, cas);
        it.req  = req;
        it.a    = a;
        it.b    = b;
        sb_q.push_back(it);
    endtask

    // Monitor: compares each result half a cycle after it was driven.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                checks++;
                if ({gt_o, eq_o, lt_o} !== it.expv) begin
                    failures++;
                    $display("FAIL %s a=%02h b=%02h actual=%b expected=%b",
                             it.req, it.a, it.b, {gt_o, eq_o, lt_o}, it.expv);
                end
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Output state at start with the tie-off and zero operands.
        drive(8'h00, 8'h00, 3'b010, "R3 initial");
        // R1 R2 R3: exhaustive sweep with the tie-off.
        for (int i = 0; i < 65536; i++) begin
            drive(i[15:8], i[7:0], 3'b010, "R1 R2 R3 sweep");
        end
        // R4: highest differing bit decides, lower bits opposite.
        drive(8'h80, 8'h7F, 3'b010, "R4 msb");
        drive(8'h7F, 8'h80, 3'b010, "R4 msb");
        drive(8'h05, 8'h03, 3'b001, "R4 bit2");
        drive(8'h02, 8'h01, 3'b100, "R4 bit1");
        // R5: equal words pass each one-hot cascade code.
        drive(8'hA5, 8'hA5, 3'b100, "R5 gt");
        drive(8'hA5, 8'hA5, 3'b010, "R5 eq");
        drive(8'h3C, 8'h3C, 3'b001, "R5 lt");
        // R6: differing words ignore every cascade value.
        for (int c = 0; c < 8; c++) begin
            drive(8'h41, 8'h40, c[2:0], "R6 gt");
            drive(8'h10, 8'h90, c[2:0], "R6 lt");
        end
        // R7: non-one-hot cascade copied unchanged on equal words.
        drive(8'h66, 8'h66, 3'b000, "R7 zero");
        drive(8'hFF, 8'hFF, 3'b111, "R7 all");
        drive(8'h00, 8'h00, 3'b101, "R7 gtlt");
        drive(8'h12, 8'h12, 3'b011, "R7 eqlt");
        // R9: low stage decides through the link, high stage overrides.
        drive(8'h35, 8'h34, 3'b001, "R9 low gt");
        drive(8'h34, 8'h3F, 3'b100, "R9 low lt");
        drive(8'h1F, 8'h20, 3'b010, "R9 high lt");
        drive(8'hE0, 8'hDF, 3'b010, "R9 high gt");
        // R8: one-hot cascade gives one-hot outputs (reference is one-hot).
        drive(8'hC3, 8'hC3, 3'b010, "R8");
        repeat (4) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule